// File: doc/BRIEF.md
# Freeze-Aware Conversion Queue Sequencer

This block walks an analog-to-digital converter through a queue of conversion command words (CCWs). It issues a one-cycle start pulse for each entry and waits for the converter's done strobe. It then moves to the next entry. A scan ends when it reaches the last slot or an entry whose channel field holds the end-of-queue code, and the sequencer then returns to idle with its pointer at entry 0. A 2-bit queue mode selects what starts a scan: nothing, a rising edge on the external trigger, continuous restart, or the internal interval timer. The block also contains the conversion-clock prescaler and the interval timer.

A debug freeze request, qualified by a freeze-enable bit, halts the sequencer. While halted, the prescaler and timer are held cleared and trigger edges are dropped. The CCW table and the mode stay writable while halted. If a conversion is in flight, the sequencer normally finishes it and advances the pointer before it halts. A mode change or a queue abort during a conversion halts it immediately instead. On release, the sequencer picks the next entry from the mode, the saved pointer and any pending trigger.

Top module: `cq_freeze_seq`

## Requirements
- R1: After reset the pointer is 0, no start pulse is given, the mode is off (0), and all 16 CCW entries read 0.
- R2: Outside freeze, qclk_en pulses once every PRESC_DIV cycles and tick pulses on every TIMER_TICKS-th qclk_en pulse. While frozen, both outputs stay low and both counts restart from zero.
- R3: Mode encoding is 0 off, 1 external trigger, 2 continuous, 3 interval timer. In mode 1 a rising edge of ext_trig sets a pending trigger, and in mode 3 a tick sets it. An edge or tick that occurs while frozen is dropped.
- R4: In idle, when the mode is 2, or the mode is nonzero and a trigger is pending, the block clears the pending trigger and raises conv_start one cycle later at the current pointer. Each conv_done advances the pointer and starts the next entry. A scan ends, with the pointer set to 0 and the block back in idle, when the next entry's low 6 bits equal 0x3F or the finished entry was slot 15.
- R5: While frz_en is 0, frz_req has no effect.
- R6: A freeze request during a conversion takes effect only at conv_done. The pointer advances first and then holds while frozen.
- R7: An abort, or a mode write with a different value, during a conversion freezes the block on the next cycle without conv_done, and the pointer is left unchanged.
- R8: If the freeze was forced, or the mode was written or an abort arrived while frozen, release sets the pointer to 0, returns to idle and clears the pending trigger.
- R9: Otherwise, if the block was frozen with a scan in progress and a trigger is pending or the mode is 2, release issues conv_start at the saved pointer. If not, the block idles at the saved pointer and resumes there on the next trigger.
- R10: CCW table writes and reads through ccw_raddr/ccw_rdata work in every state, including freeze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frz_req | input | 1 | Debug freeze request |
| frz_en | input | 1 | Freeze enable; gates frz_req |
| ext_trig | input | 1 | External trigger level (rising edge used) |
| mode_wr | input | 1 | Queue mode write strobe |
| mode_wdata | input | 2 | Queue mode value |
| q_abort | input | 1 | Queue abort strobe |
| conv_done | input | 1 | Conversion finished strobe from converter |
| ccw_wr | input | 1 | CCW table write strobe |
| ccw_waddr | input | 4 | CCW write address |
| ccw_wdata | input | 8 | CCW write data; bits 5:0 channel |
| ccw_raddr | input | 4 | CCW read address |
| ccw_rdata | output | 8 | CCW read data (combinational) |
| ccw_ptr | output | 4 | Current / saved CCW pointer |
| conv_start | output | 1 | One-cycle conversion start pulse |
| qclk_en | output | 1 | Conversion clock enable pulse |
| tick | output | 1 | Interval timer tick |

## Verification
The embedded assertions check several rules on every cycle. The prescaler and timer are silent after a freeze cycle. No trigger is captured while frozen. The pointer holds during a requested freeze. A conversion waits for its done strobe unless an abort or mode change forces a freeze, and frz_en low prevents any requested freeze. Start pulses occur only in the converting state, and a table write lands at the addressed entry. The bench scenarios cover the release decisions: restart, resume at the saved pointer, or idle at the saved pointer. They also cover end-of-queue handling and the interaction of trigger edges with freeze. These behaviours depend on the history of several inputs, and the reference model tracks that history cycle by cycle.

// File: rtl/cq_pkg.sv
// Package: shared state and mode encodings for the CCW queue sequencer.
package cq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CONV   = 2'd1,
        ST_FROZEN = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        QM_OFF   = 2'd0,
        QM_EXT   = 2'd1,
        QM_CONT  = 2'd2,
        QM_TIMER = 2'd3
    } qmode_t;
endpackage

// File: rtl/cq_clkgen.sv
// Module: conversion clock prescaler and interval timer.
// Produces a qclk_en pulse every PRESC_DIV cycles and a tick on every
// TIMER_TICKS-th qclk_en. Assumes hold is high for every frozen cycle;
// while hold is high both counters sit at zero and no pulse is given.
module cq_clkgen #(
    parameter int PRESC_DIV   = 4,
    parameter int TIMER_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic qclk_en,
    output logic tick
);
    localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
    localparam int TW = (TIMER_TICKS > 1) ? $clog2(TIMER_TICKS) : 1;
    localparam logic [PW-1:0] P_LAST = PW'(PRESC_DIV - 1);
    localparam logic [TW-1:0] T_LAST = TW'(TIMER_TICKS - 1);

    logic [PW-1:0] pre_cnt;
    logic [TW-1:0] tmr_cnt;

    assign qclk_en = !hold && (pre_cnt == P_LAST);
    assign tick    = qclk_en && (tmr_cnt == T_LAST);

    // Prescaler count: wraps at PRESC_DIV, cleared while held.
    always_ff @(posedge clk) begin
        if (!rst_n || hold)          pre_cnt <= '0;
        else if (pre_cnt == P_LAST)  pre_cnt <= '0;
        else                         pre_cnt <= pre_cnt + 1'b1;
    end

    // Interval timer: counts qclk_en pulses, cleared while held.
    always_ff @(posedge clk) begin
        if (!rst_n || hold)          tmr_cnt <= '0;
        else if (qclk_en)            tmr_cnt <= (tmr_cnt == T_LAST) ? '0 : tmr_cnt + 1'b1;
    end

    generate
        if (PRESC_DIV > 1) begin : g_chk
            // R2: a frozen cycle leaves the next cycle without a clock pulse
            p_quiet_after_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
                hold |=> !qclk_en);
            // R2: clock enable is a single-cycle pulse
            p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
                qclk_en |=> !qclk_en);
        end
    endgenerate
endmodule

// File: rtl/cq_trig.sv
// Module: trigger capture. Detects rising edges of ext_trig (mode 1) or
// timer ticks (mode 3) and keeps one pending flag. Assumes hold marks the
// frozen state; captures are dropped while it is high. Set beats clear.
module cq_trig (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold,
    input  logic [1:0] mode,
    input  logic       ext_trig,
    input  logic       tick,
    input  logic       pend_clr,
    output logic       pend
);
    import cq_pkg::*;

    logic trig_prev;
    logic cap;

    assign cap = !hold && (((qmode_t'(mode) == QM_EXT) && ext_trig && !trig_prev) ||
                           ((qmode_t'(mode) == QM_TIMER) && tick));

    // Previous trigger level for edge detection, tracked in every state.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_prev <= 1'b0;
        else        trig_prev <= ext_trig;
    end

    // Pending flag: set on capture, cleared when the sequencer consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend <= 1'b0;
        else if (cap)      pend <= 1'b1;
        else if (pend_clr) pend <= 1'b0;
    end

    // R3: nothing becomes pending while frozen
    p_no_capture_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !pend) |=> !pend);
endmodule

// File: rtl/cq_ccw_table.sv
// Module: CCW storage with one write port, one read port for the register
// path and two end-of-queue lookups for the sequencer. Assumes the channel
// field is the low CHAN_W bits; all ones there marks end of queue.
module cq_ccw_table #(
    parameter int DEPTH  = 16,
    parameter int CCW_W  = 8,
    parameter int CHAN_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [CCW_W-1:0]         wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [CCW_W-1:0]         rd_data,
    input  logic [$clog2(DEPTH)-1:0] look_a,
    input  logic [$clog2(DEPTH)-1:0] look_b,
    output logic                     eoq_a,
    output logic                     eoq_b
);
    localparam logic [CHAN_W-1:0] EOQ_CODE = '1;

    logic [CCW_W-1:0] mem [DEPTH];

    // Table storage: cleared at reset, written from the register path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
    assign eoq_a   = (mem[look_a][CHAN_W-1:0] == EOQ_CODE);
    assign eoq_b   = (mem[look_b][CHAN_W-1:0] == EOQ_CODE);

    // R10: a write is visible at its address on the next cycle
    p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/cq_seq_core.sv
// Module: queue sequencer state machine. Holds the mode, the CCW pointer
// and the freeze bookkeeping, and decides what runs on leaving freeze.
// Assumes eoq_cur/eoq_nxt describe entries ptr and ptr+1 of the table.
module cq_seq_core #(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frz_req,
    input  logic                     frz_en,
    input  logic                     mode_wr,
    input  logic [1:0]               mode_wdata,
    input  logic                     q_abort,
    input  logic                     conv_done,
    input  logic                     pend,
    input  logic                     eoq_cur,
    input  logic                     eoq_nxt,
    output logic [$clog2(DEPTH)-1:0] ptr,
    output logic                     conv_start,
    output logic                     frozen,
    output logic [1:0]               mode,
    output logic                     pend_clr
);
    import cq_pkg::*;

    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] P_LAST = PTR_W'(DEPTH - 1);

    seq_state_t state;
    qmode_t     mode_q;
    logic       active_q;
    logic       restart_q;
    logic       eff_frz, go, mode_chg, last, restart_now, resume_ok;

    assign eff_frz     = frz_en && frz_req;
    assign go          = (mode_q == QM_CONT) || ((mode_q != QM_OFF) && pend);
    assign mode_chg    = mode_wr && (qmode_t'(mode_wdata) != mode_q);
    assign last        = (ptr == P_LAST) || eoq_nxt;
    assign restart_now = restart_q || mode_wr || q_abort;
    assign resume_ok   = active_q && (pend || (mode_q == QM_CONT));

    assign frozen = (state == ST_FROZEN);
    assign mode   = mode_q;

    // Pending trigger consumed on a scan start, an idle abort or a freeze exit.
    always_comb begin
        pend_clr = 1'b0;
        if (state == ST_IDLE)
            pend_clr = !eff_frz && (q_abort || go);
        else if (state == ST_FROZEN)
            pend_clr = !eff_frz && (restart_now || resume_ok);
    end

    // Mode register: always writable, including during freeze.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= QM_OFF;
        else if (mode_wr) mode_q <= qmode_t'(mode_wdata);
    end

    // Sequencer: scan stepping, freeze entry and the release decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            ptr        <= '0;
            conv_start <= 1'b0;
            active_q   <= 1'b0;
            restart_q  <= 1'b0;
        end else begin
            conv_start <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (eff_frz) begin
                        state     <= ST_FROZEN;
                        active_q  <= 1'b0;
                        restart_q <= 1'b0;
                    end else if (q_abort) begin
                        ptr <= '0;
                    end else if (go) begin
                        if (eoq_cur) begin
                            ptr <= '0;
                        end else begin
                            state      <= ST_CONV;
                            conv_start <= 1'b1;
                        end
                    end
                end
                ST_CONV: begin
                    if (q_abort || mode_chg) begin
                        state     <= ST_FROZEN;
                        active_q  <= 1'b1;
                        restart_q <= 1'b1;
                    end else if (conv_done) begin
                        ptr <= last ? '0 : ptr + 1'b1;
                        if (eff_frz) begin
                            state     <= ST_FROZEN;
                            active_q  <= !last;
                            restart_q <= 1'b0;
                        end else if (last) begin
                            state <= ST_IDLE;
                        end else begin
                            conv_start <= 1'b1;
                        end
                    end
                end
                ST_FROZEN: begin
                    if (!eff_frz) begin
                        restart_q <= 1'b0;
                        if (restart_now) begin
                            ptr   <= '0;
                            state <= ST_IDLE;
                        end else if (resume_ok && !eoq_cur) begin
                            state      <= ST_CONV;
                            conv_start <= 1'b1;
                        end else if (resume_ok) begin
                            ptr   <= '0;
                            state <= ST_IDLE;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else if (mode_wr || q_abort) begin
                        restart_q <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5: with freeze disabled only an abort or mode write can freeze
    p_enable_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!frz_en && (state != ST_FROZEN) && !q_abort && !mode_wr) |=> (state != ST_FROZEN));
    // R6: a plain conversion waits for its done strobe
    p_wait_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_CONV) && !conv_done && !q_abort && !mode_wr) |=> (state == ST_CONV));
    // R6: pointer is held while a requested freeze persists
    p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_FROZEN) && eff_frz) |=> $stable(ptr));
    // R7: abort during a conversion freezes at once, pointer kept
    p_abort_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_CONV) && q_abort) |=> ((state == ST_FROZEN) && $stable(ptr)));
    // R4: start pulses only accompany the converting state
    p_start_in_conv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (state == ST_CONV));
endmodule

// File: rtl/cq_freeze_seq.sv
// Module: top of the freeze-aware CCW queue sequencer. Connects the
// sequencer core, CCW table, trigger capture and clock/timer generator.
// Assumes a single clock domain and an already synchronised ext_trig.
module cq_freeze_seq #(
    parameter int DEPTH       = 16,
    parameter int CCW_W       = 8,
    parameter int CHAN_W      = 6,
    parameter int PRESC_DIV   = 4,
    parameter int TIMER_TICKS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frz_req,
    input  logic                     frz_en,
    input  logic                     ext_trig,
    input  logic                     mode_wr,
    input  logic [1:0]               mode_wdata,
    input  logic                     q_abort,
    input  logic                     conv_done,
    input  logic                     ccw_wr,
    input  logic [$clog2(DEPTH)-1:0] ccw_waddr,
    input  logic [CCW_W-1:0]         ccw_wdata,
    input  logic [$clog2(DEPTH)-1:0] ccw_raddr,
    output logic [CCW_W-1:0]         ccw_rdata,
    output logic [$clog2(DEPTH)-1:0] ccw_ptr,
    output logic                     conv_start,
    output logic                     qclk_en,
    output logic                     tick
);
    localparam int PTR_W = $clog2(DEPTH);

    logic             frozen, pend, pend_clr, eoq_cur, eoq_nxt;
    logic [1:0]       mode;
    logic [PTR_W-1:0] ptr_nxt;

    assign ptr_nxt = ccw_ptr + 1'b1;

    cq_seq_core #(.DEPTH(DEPTH)) u_core (
        .clk(clk), .rst_n(rst_n), .frz_req(frz_req), .frz_en(frz_en),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata), .q_abort(q_abort),
        .conv_done(conv_done), .pend(pend), .eoq_cur(eoq_cur), .eoq_nxt(eoq_nxt),
        .ptr(ccw_ptr), .conv_start(conv_start), .frozen(frozen), .mode(mode),
        .pend_clr(pend_clr)
    );

    cq_ccw_table #(.DEPTH(DEPTH), .CCW_W(CCW_W), .CHAN_W(CHAN_W)) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(ccw_wr), .wr_addr(ccw_waddr),
        .wr_data(ccw_wdata), .rd_addr(ccw_raddr), .rd_data(ccw_rdata),
        .look_a(ccw_ptr), .look_b(ptr_nxt), .eoq_a(eoq_cur), .eoq_b(eoq_nxt)
    );

    cq_trig u_trig (
        .clk(clk), .rst_n(rst_n), .hold(frozen), .mode(mode), .ext_trig(ext_trig),
        .tick(tick), .pend_clr(pend_clr), .pend(pend)
    );

    cq_clkgen #(.PRESC_DIV(PRESC_DIV), .TIMER_TICKS(TIMER_TICKS)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .hold(frozen), .qclk_en(qclk_en), .tick(tick)
    );
endmodule

// File: tb/cq_freeze_seq_bench.sv
module cq_freeze_seq_bench;
    localparam int DIV = 4;
    localparam int TT  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frz_req = 0, frz_en = 0, ext_trig = 0, mode_wr = 0, q_abort = 0, conv_done = 0;
    logic [1:0] mode_wdata = 0;
    logic       ccw_wr = 0;
    logic [3:0] ccw_waddr = 0, ccw_raddr = 0;
    logic [7:0] ccw_wdata = 0;
    logic [7:0] ccw_rdata;
    logic [3:0] ccw_ptr;
    logic       conv_start, qclk_en, tick;

    int n_checks = 0, n_fail = 0;
    int qen_cnt = 0, tick_cnt = 0, start_cnt = 0;
    bit cmp_on = 0;

    // reference model state
    int m_st, m_ptr, m_mode, m_pend, m_act, m_rst, m_pc, m_tc, m_prev, m_start;
    logic [7:0] m_mem [16];

    always #2 clk = ~clk;

    cq_freeze_seq #(.PRESC_DIV(DIV), .TIMER_TICKS(TT)) u_cq_freeze_seq (
        .clk(clk), .rst_n(rst_n), .frz_req(frz_req), .frz_en(frz_en), .ext_trig(ext_trig),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata), .q_abort(q_abort), .conv_done(conv_done),
        .ccw_wr(ccw_wr), .ccw_waddr(ccw_waddr), .ccw_wdata(ccw_wdata), .ccw_raddr(ccw_raddr),
        .ccw_rdata(ccw_rdata), .ccw_ptr(ccw_ptr), .conv_start(conv_start),
        .qclk_en(qclk_en), .tick(tick)
    );

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit is_eoq(int i);
        return m_mem[i % 16][5:0] == 6'h3F;
    endfunction

    // Behavioural reference, advanced on each rising edge from the inputs.
    always @(posedge clk) begin : ref_model
        int nst, nptr, st, clr, eff, qen, tk, setp, lastq, rnow, resume;
        if (!rst_n) begin
            m_st = 0; m_ptr = 0; m_mode = 0; m_pend = 0; m_act = 0; m_rst = 0;
            m_pc = 0; m_tc = 0; m_prev = 0; m_start = 0;
            foreach (m_mem[i]) m_mem[i] = 8'h00;
        end else begin
            qen  = (m_st != 2 && m_pc == DIV - 1);
            tk   = qen && (m_tc == TT - 1);
            eff  = frz_en && frz_req;
            setp = (m_st != 2) && ((m_mode == 1 && ext_trig && !m_prev) || (m_mode == 3 && tk));
            clr = 0; st = 0; nst = m_st; nptr = m_ptr;
            if (m_st == 0) begin
                if (eff) begin nst = 2; m_act = 0; m_rst = 0; end
                else if (q_abort) begin nptr = 0; clr = 1; end
                else if (m_mode == 2 || (m_mode != 0 && m_pend)) begin
                    clr = 1;
                    if (is_eoq(m_ptr)) nptr = 0; else begin nst = 1; st = 1; end
                end
            end else if (m_st == 1) begin
                if (q_abort || (mode_wr && int'(mode_wdata) != m_mode)) begin
                    nst = 2; m_act = 1; m_rst = 1;
                end else if (conv_done) begin
                    lastq = (m_ptr == 15) || is_eoq(m_ptr + 1);
                    nptr = lastq ? 0 : m_ptr + 1;
                    if (eff) begin nst = 2; m_act = !lastq; m_rst = 0; end
                    else if (lastq) nst = 0;
                    else st = 1;
                end
            end else begin
                rnow = m_rst || mode_wr || q_abort;
                if (!eff) begin
                    m_rst = 0;
                    resume = m_act && (m_pend || m_mode == 2);
                    if (rnow) begin nptr = 0; nst = 0; clr = 1; end
                    else if (resume) begin
                        clr = 1;
                        if (is_eoq(m_ptr)) begin nptr = 0; nst = 0; end
                        else begin nst = 1; st = 1; end
                    end else nst = 0;
                end else if (mode_wr || q_abort) m_rst = 1;
            end
            if (setp) m_pend = 1; else if (clr) m_pend = 0;
            if (m_st == 2) begin m_pc = 0; m_tc = 0; end
            else begin
                if (qen) m_tc = (m_tc == TT - 1) ? 0 : m_tc + 1;
                m_pc = (m_pc == DIV - 1) ? 0 : m_pc + 1;
            end
            if (mode_wr) m_mode = int'(mode_wdata);
            if (ccw_wr) m_mem[ccw_waddr] = ccw_wdata;
            m_prev = ext_trig;
            m_st = nst; m_ptr = nptr; m_start = st;
        end
    end

    // Compare every cycle at the falling edge and count observed pulses.
    always @(negedge clk) begin : cmp
        int eq, et;
        if (cmp_on) begin
            eq = (m_st != 2 && m_pc == DIV - 1);
            et = eq && (m_tc == TT - 1);
            check(int'(ccw_ptr) == m_ptr, "R4 pointer", ccw_ptr, m_ptr);
            check(int'(conv_start) == m_start, "R4 conv_start", conv_start, m_start);
            check(int'(qclk_en) == eq, "R2 qclk_en", qclk_en, eq);
            check(int'(tick) == et, "R2 tick", tick, et);
            check(ccw_rdata == m_mem[ccw_raddr], "R10 ccw_rdata", ccw_rdata, m_mem[ccw_raddr]);
            qen_cnt += qclk_en; tick_cnt += tick; start_cnt += conv_start;
        end
    end

    task automatic cyc(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic pulse_done();
        conv_done = 1; cyc(1); conv_done = 0;
    endtask

    task automatic write_mode(int v);
        mode_wr = 1; mode_wdata = 2'(v); cyc(1); mode_wr = 0;
    endtask

    task automatic pulse_trig();
        ext_trig = 1; cyc(1); ext_trig = 0;
    endtask

    task automatic wait_start(int lim, string req, int exp_ptr);
        bit seen = 0;
        for (int i = 0; i < lim && !seen; i++) begin
            @(negedge clk);
            if (conv_start) seen = 1;
        end
        check(seen, req, seen, 1);
        if (seen) check(int'(ccw_ptr) == exp_ptr, req, ccw_ptr, exp_ptr);
    endtask

    initial begin : watchdog
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        cyc(3);
        rst_n = 1;
        cmp_on = 1;
        @(negedge clk);
        // R1: reset state
        check(ccw_ptr == 0, "R1 pointer", ccw_ptr, 0);
        check(conv_start == 0, "R1 conv_start", conv_start, 0);
        check(ccw_rdata == 0, "R1 table entry", ccw_rdata, 0);

        // table: entries 0..4 channels, entry 5 end-of-queue, rest channel 1
        for (int i = 0; i < 16; i++) begin
            ccw_wr = 1; ccw_waddr = 4'(i);
            ccw_wdata = (i < 5) ? 8'(i) : (i == 5) ? 8'h3F : 8'h01;
            cyc(1);
        end
        ccw_wr = 0;

        // R4: continuous scan to end-of-queue and restart
        write_mode(2);
        wait_start(10, "R4 continuous start", 0);
        for (int i = 0; i < 5; i++) begin cyc(2); pulse_done(); end
        @(negedge clk);
        check(ccw_ptr == 0, "R4 end of queue pointer", ccw_ptr, 0);
        wait_start(5, "R4 rescan", 0);
        cyc(1); pulse_done();

        // R7: mode change mid-conversion freezes at once
        cyc(1); write_mode(1);
        @(negedge clk);
        check(ccw_ptr == 1, "R7 pointer kept", ccw_ptr, 1);
        check(qclk_en == 0, "R7 frozen clock", qclk_en, 0);
        start_cnt = 0; cyc(10);
        check(ccw_ptr == 0, "R8 restart pointer", ccw_ptr, 0);
        check(start_cnt == 0, "R8 stays idle", start_cnt, 0);

        // R3: external trigger starts a mode 1 scan
        pulse_trig();
        wait_start(5, "R3 trigger start", 0);
        cyc(1); pulse_done();

        // R6: freeze request waits for done
        frz_en = 1; frz_req = 1; qen_cnt = 0;
        cyc(8);
        check(ccw_ptr == 1, "R6 waits for done", ccw_ptr, 1);
        check(qen_cnt > 0, "R6 clock still running", qen_cnt, 1);
        pulse_done();
        qen_cnt = 0; tick_cnt = 0;
        pulse_trig();
        ccw_wr = 1; ccw_waddr = 7; ccw_wdata = 8'h15; cyc(1); ccw_wr = 0;
        ccw_raddr = 7;
        cyc(40);
        check(qen_cnt == 0, "R2 frozen qclk_en", qen_cnt, 0);
        check(tick_cnt == 0, "R2 frozen tick", tick_cnt, 0);
        check(ccw_ptr == 2, "R6 saved pointer", ccw_ptr, 2);
        @(negedge clk);
        check(ccw_rdata == 8'h15, "R10 write in freeze", ccw_rdata, 8'h15);
        frz_req = 0; start_cnt = 0;
        cyc(12);
        check(start_cnt == 0, "R3 frozen trigger dropped", start_cnt, 0);
        check(ccw_ptr == 2, "R9 idle at saved pointer", ccw_ptr, 2);
        pulse_trig();
        wait_start(5, "R9 trigger resumes saved pointer", 2);

        // R5: freeze disabled, request ignored
        frz_en = 0; frz_req = 1;
        cyc(1); pulse_done();
        @(negedge clk);
        check(conv_start == 1, "R5 next start", conv_start, 1);
        check(ccw_ptr == 3, "R5 pointer advanced", ccw_ptr, 3);
        qen_cnt = 0; cyc(8);
        check(qen_cnt > 0, "R5 clock running", qen_cnt, 1);
        frz_req = 0;

        // R7/R8: abort mid-conversion
        q_abort = 1; cyc(1); q_abort = 0;
        @(negedge clk);
        check(ccw_ptr == 3, "R7 abort keeps pointer", ccw_ptr, 3);
        check(qclk_en == 0, "R7 abort frozen", qclk_en, 0);
        start_cnt = 0; cyc(6);
        check(ccw_ptr == 0, "R8 abort restart", ccw_ptr, 0);
        check(start_cnt == 0, "R8 abort idle", start_cnt, 0);

        // R9: continuous resume at saved pointer
        write_mode(2);
        wait_start(10, "R4 continuous start", 0);
        cyc(1); pulse_done(); cyc(1); pulse_done();
        frz_en = 1; frz_req = 1; cyc(1); pulse_done();
        cyc(4);
        check(ccw_ptr == 3, "R6 saved pointer", ccw_ptr, 3);
        frz_req = 0;
        wait_start(5, "R9 continuous resume", 3);

        // R8: mode rewritten during freeze restarts
        frz_req = 1; cyc(1); pulse_done();
        cyc(2); write_mode(2); cyc(2);
        check(ccw_ptr == 4, "R6 saved pointer", ccw_ptr, 4);
        frz_req = 0;
        wait_start(5, "R8 restart at first entry", 0);

        // R3: interval timer mode
        cyc(1); write_mode(3);
        cyc(3); tick_cnt = 0;
        wait_start(80, "R3 timer start", 0);
        check(tick_cnt > 0, "R3 tick before start", tick_cnt, 1);
        for (int i = 0; i < 5; i++) begin cyc(1); pulse_done(); end
        cyc(5);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule